// File: doc/BRIEF.md
# Double-Buffered Synthesizer Frequency Register Bank

This block sits behind a serial-port slave in a fractional-N synthesizer controller. It holds shadow copies of the integer and fractional frequency words. It decides when those shadow copies are moved to the active words that drive the modulator. Each such move is a frequency hop. It also holds the function-enable word and a mode word that selects fractional or integer operation, and it carries out the two self-clearing reset strobes.

The serial slave passes in decoded write requests, each with an address and data. It also passes in a strobe that marks the falling edge of the 31st serial clock of the 32-clock frame. A request is held as pending and is committed only on that strobe, so a hop always lines up with the same bit of the frame.

Which write causes a hop depends on the mode:

- **Fractional mode:** an integer-word write only loads its shadow copy. The next fractional-word write then moves both words to the active outputs together.
- **Integer mode:** the integer-word write itself causes the hop. A fractional-word write only loads its shadow copy.

Top module: `fbank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register returns to its default: integer shadow `INT_RST`, fractional shadow `FRAC_RST`, enable `EN_RST`, mode 1 (fractional). The active words return to zero and `hop` is low.
- R2: A write request changes nothing until the next `bit31_stb`. The committed values become visible at the edge that samples that strobe.
- R3: In fractional mode (mode bit 0 of address 0x12 = 1), a write to address 0x0F updates only the integer shadow. It causes no hop, and the active words stay unchanged.
- R4: In fractional mode, a write to address 0x10 copies both shadows (the new fractional value included) to `act_int` and `act_frac` at the commit edge. At that same edge `hop` goes high for exactly one clock.
- R5: In integer mode (mode bit 0 = 0), a write to address 0x0F copies both shadows to the active words and pulses `hop` for one clock.
- R6: In integer mode, a write to address 0x10 updates only the fractional shadow. It causes no hop.
- R7: A write to address 0x00 with data bit 0 set restores the integer shadow, fractional shadow, enable word and mode to their defaults. It leaves the active words unchanged.
- R8: A write to address 0x00 with data bit 1 set clears the active words to zero. It leaves the shadow, enable and mode registers unchanged.
- R9: Address 0x01 holds the 16-bit enable word. `pwr_down` is high exactly when that word is zero, and writing a saved value back restores it.
- R10: Reads at addresses 0x01, 0x0F, 0x10 and 0x12 return the shadow or register value, never the active word.
- R11: Writes to any other address change nothing, and reads of any other address (including 0x00) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_req | input | 1 | Decoded write request from the serial slave |
| wr_addr | input | ADDR_W | Register address of the request |
| wr_data | input | DATA_W | Data of the request |
| bit31_stb | input | 1 | One-cycle strobe at the falling edge of serial clock 31 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Readback of the addressed register (shadow value) |
| act_int | output | INT_W | Active integer frequency word |
| act_frac | output | FRAC_W | Active fractional frequency word |
| hop | output | 1 | One-cycle frequency hop pulse |
| frac_mode | output | 1 | 1 = fractional mode, 0 = integer mode |
| en_out | output | EN_W | Function-enable word |
| pwr_down | output | 1 | High when the enable word is zero |

## Verification
The bench builds the block with the default widths: 16-bit integer word, 24-bit fractional word, 24-bit data. It overrides the reset values to nonzero patterns (`INT_RST` 0x0050, `FRAC_RST` 0x000100, `EN_RST` 0xA5A5), so a register restore can be told apart from the clear of the active words. The 24-bit fractional word shows that the integer shadow keeps only its low bits of a wide write. The distinct enable pattern shows that the save-and-restore through power-down returns the exact prior word rather than all ones.

// File: rtl/fbank_pkg.sv
// Package: shared register addresses and decoded register select for the
// frequency register bank. Assumes an address field of at least 8 bits.
package fbank_pkg;

    localparam logic [7:0] ADR_STRB = 8'h00;
    localparam logic [7:0] ADR_EN   = 8'h01;
    localparam logic [7:0] ADR_INT  = 8'h0F;
    localparam logic [7:0] ADR_FRAC = 8'h10;
    localparam logic [7:0] ADR_MODE = 8'h12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STRB,
        SEL_EN,
        SEL_INT,
        SEL_FRAC,
        SEL_MODE
    } reg_sel_e;

    // Map an 8-bit address to a register select.
    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADR_STRB: return SEL_STRB;
            ADR_EN:   return SEL_EN;
            ADR_INT:  return SEL_INT;
            ADR_FRAC: return SEL_FRAC;
            ADR_MODE: return SEL_MODE;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fbank_stage.sv
// Module: fbank_stage
// Holds one decoded write request until the bit-31 strobe of the frame and
// presents it as a commit for that single cycle.
// Assumes: at most one request per frame; a request arriving in the same
// cycle as the strobe waits for the following strobe.
module fbank_stage
    import fbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit31_stb,
    output logic              cm_vld,
    output reg_sel_e          cm_sel,
    output logic [DATA_W-1:0] cm_data
);

    localparam int DEC_W = (ADDR_W < 8) ? ADDR_W : 8;

    logic              pend_q;
    reg_sel_e          sel_q;
    logic [DATA_W-1:0] data_q;
    logic [7:0]        addr8;

    // Widen or trim the incoming address to the 8-bit decode field.
    always_comb begin
        addr8 = '0;
        addr8[DEC_W-1:0] = wr_addr[DEC_W-1:0];
    end

    // Capture a request; drop the pending flag once it has been committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            sel_q  <= SEL_NONE;
            data_q <= '0;
        end else if (wr_req) begin
            pend_q <= 1'b1;
            sel_q  <= decode_addr(addr8);
            data_q <= wr_data;
        end else if (bit31_stb) begin
            pend_q <= 1'b0;
        end
    end

    // Present the pending request only on the strobe cycle.
    always_comb begin
        cm_vld  = pend_q && bit31_stb;
        cm_sel  = sel_q;
        cm_data = data_q;
    end

endmodule

// File: rtl/fbank_regs.sv
// Module: fbank_regs
// Shadow register file: integer word, fractional word, enable word and mode.
// Performs the register-restore strobe, raises the hop request according to
// the mode, and drives the readback mux from shadow values.
// Assumes commits arrive from fbank_stage, at most one per cycle.
module fbank_regs
    import fbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 24,
    parameter int EN_W   = 16,
    parameter logic [INT_W-1:0]  INT_RST  = '0,
    parameter logic [FRAC_W-1:0] FRAC_RST = '0,
    parameter logic [EN_W-1:0]   EN_RST   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cm_vld,
    input  reg_sel_e          cm_sel,
    input  logic [DATA_W-1:0] cm_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [INT_W-1:0]  sh_int,
    output logic [FRAC_W-1:0] sh_frac,
    output logic [INT_W-1:0]  nxt_int,
    output logic [FRAC_W-1:0] nxt_frac,
    output logic [EN_W-1:0]   en_q,
    output logic              mode_q,
    output logic              hop_req,
    output logic              dig_clr
);

    localparam int DEC_W = (ADDR_W < 8) ? ADDR_W : 8;

    logic     regs_clr;
    logic     wr_int, wr_frac, wr_en, wr_mode;
    logic [7:0] raddr8;

    // Decode the commit into per-register write enables and strobes.
    always_comb begin
        wr_int   = cm_vld && (cm_sel == SEL_INT);
        wr_frac  = cm_vld && (cm_sel == SEL_FRAC);
        wr_en    = cm_vld && (cm_sel == SEL_EN);
        wr_mode  = cm_vld && (cm_sel == SEL_MODE);
        regs_clr = cm_vld && (cm_sel == SEL_STRB) && cm_data[0];
        dig_clr  = cm_vld && (cm_sel == SEL_STRB) && cm_data[1];
    end

    // Next shadow values, which a hop copies to the active words.
    always_comb begin
        nxt_int  = wr_int  ? cm_data[INT_W-1:0]  : sh_int;
        nxt_frac = wr_frac ? cm_data[FRAC_W-1:0] : sh_frac;
    end

    // The mode decides which word's write triggers the hop.
    always_comb hop_req = (wr_frac && mode_q) || (wr_int && !mode_q);

    // Shadow, enable and mode storage with restore strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || regs_clr) begin
            sh_int  <= INT_RST;
            sh_frac <= FRAC_RST;
            en_q    <= EN_RST;
            mode_q  <= 1'b1;
        end else begin
            sh_int  <= nxt_int;
            sh_frac <= nxt_frac;
            if (wr_en)   en_q   <= cm_data[EN_W-1:0];
            if (wr_mode) mode_q <= cm_data[0];
        end
    end

    // Readback mux returning shadow values only.
    always_comb begin
        raddr8 = '0;
        raddr8[DEC_W-1:0] = rd_addr[DEC_W-1:0];
        rd_data = '0;
        case (decode_addr(raddr8))
            SEL_EN:   rd_data[EN_W-1:0]   = en_q;
            SEL_INT:  rd_data[INT_W-1:0]  = sh_int;
            SEL_FRAC: rd_data[FRAC_W-1:0] = sh_frac;
            SEL_MODE: rd_data[0]          = mode_q;
            default:  rd_data = '0;
        endcase
    end

    // R2
    hold_wo_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_vld |=> ($stable(sh_int) && $stable(sh_frac) && $stable(en_q) && $stable(mode_q)));

    // R7
    regs_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clr |=> (sh_int == INT_RST && sh_frac == FRAC_RST && en_q == EN_RST && mode_q));

endmodule

// File: rtl/fbank_hop.sv
// Module: fbank_hop
// Active frequency words and hop pulse. A hop request loads both next
// shadow values together; the digital-clear strobe zeroes the active words.
// Assumes hop requests are single-cycle commits from fbank_regs.
module fbank_hop #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hop_req,
    input  logic              dig_clr,
    input  logic [INT_W-1:0]  nxt_int,
    input  logic [FRAC_W-1:0] nxt_frac,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              hop
);

    // Load active words on a hop, clear them on the digital reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || dig_clr) begin
            act_int  <= '0;
            act_frac <= '0;
            hop      <= 1'b0;
        end else begin
            hop <= hop_req;
            if (hop_req) begin
                act_int  <= nxt_int;
                act_frac <= nxt_frac;
            end
        end
    end

    // R3
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hop_req && !dig_clr) |=> ($stable(act_int) && $stable(act_frac) && !hop));

    // R8
    dig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_clr |=> (act_int == '0 && act_frac == '0 && !hop));

endmodule

// File: rtl/fbank_top.sv
// Module: fbank_top
// Double-buffered frequency register bank for a fractional-N synthesizer.
// Commits serial writes on the bit-31 strobe, hops per the mode rules and
// exposes active words, hop pulse, mode, enable word and shadow readback.
// Assumes rst_n is synchronous and held low for at least two clocks.
module fbank_top
    import fbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 24,
    parameter int EN_W   = 16,
    parameter logic [INT_W-1:0]  INT_RST  = '0,
    parameter logic [FRAC_W-1:0] FRAC_RST = '0,
    parameter logic [EN_W-1:0]   EN_RST   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit31_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic              hop,
    output logic              frac_mode,
    output logic [EN_W-1:0]   en_out,
    output logic              pwr_down
);

    logic              cm_vld;
    reg_sel_e          cm_sel;
    logic [DATA_W-1:0] cm_data;
    logic [INT_W-1:0]  sh_int, nxt_int;
    logic [FRAC_W-1:0] sh_frac, nxt_frac;
    logic              hop_req, dig_clr;

    fbank_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .bit31_stb(bit31_stb),
        .cm_vld(cm_vld), .cm_sel(cm_sel), .cm_data(cm_data)
    );

    fbank_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
        .EN_W(EN_W), .INT_RST(INT_RST), .FRAC_RST(FRAC_RST), .EN_RST(EN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cm_vld(cm_vld), .cm_sel(cm_sel),
        .cm_data(cm_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sh_int(sh_int), .sh_frac(sh_frac), .nxt_int(nxt_int),
        .nxt_frac(nxt_frac), .en_q(en_out), .mode_q(frac_mode),
        .hop_req(hop_req), .dig_clr(dig_clr)
    );

    fbank_hop #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_hop (
        .clk(clk), .rst_n(rst_n), .hop_req(hop_req), .dig_clr(dig_clr),
        .nxt_int(nxt_int), .nxt_frac(nxt_frac),
        .act_int(act_int), .act_frac(act_frac), .hop(hop)
    );

    // Power-down follows an all-zero enable word.
    always_comb pwr_down = (en_out == '0);

    // R4
    hop_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hop |-> (act_int == sh_int && act_frac == sh_frac));

    // R6
    int_mode_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_vld && cm_sel == SEL_FRAC && !frac_mode) |=> !hop);

    // R3
    frac_mode_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_vld && cm_sel == SEL_INT && frac_mode) |=> !hop);

    // R5
    int_mode_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_vld && cm_sel == SEL_INT && !frac_mode) |=> (hop && act_int == $past(cm_data[INT_W-1:0])));

endmodule

// File: tb/fbank_top_tb.sv
module fbank_top_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 24;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 24;
    localparam int EN_W   = 16;
    localparam logic [INT_W-1:0]  INT_RST  = 16'h0050;
    localparam logic [FRAC_W-1:0] FRAC_RST = 24'h000100;
    localparam logic [EN_W-1:0]   EN_RST   = 16'hA5A5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_req = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              bit31_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              hop, frac_mode, pwr_down;
    logic [EN_W-1:0]   en_out;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R1";

    // Reference model state
    int m_int, m_frac, m_en, m_mode, m_aint, m_afrac, m_hop;
    int p_vld, p_addr, p_data;

    fbank_top #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
        .EN_W(EN_W), .INT_RST(INT_RST), .FRAC_RST(FRAC_RST), .EN_RST(EN_RST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .bit31_stb(bit31_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .act_int(act_int), .act_frac(act_frac), .hop(hop),
        .frac_mode(frac_mode), .en_out(en_out), .pwr_down(pwr_down)
    );

    always #2.5 clk = ~clk;

    function automatic int model_read(input int a);
        case (a)
            1:       return m_en;
            15:      return m_int;
            16:      return m_frac;
            18:      return m_mode;
            default: return 0;
        endcase
    endfunction

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin
        int h;
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_int = INT_RST; m_frac = FRAC_RST; m_en = EN_RST; m_mode = 1;
            m_aint = 0; m_afrac = 0; m_hop = 0; p_vld = 0;
        end else begin
            h = 0;
            if (bit31_stb && p_vld == 1) begin
                case (p_addr)
                    0: begin
                        if (p_data & 2) begin m_aint = 0; m_afrac = 0; end
                        if (p_data & 1) begin
                            m_int = INT_RST; m_frac = FRAC_RST; m_en = EN_RST; m_mode = 1;
                        end
                    end
                    1:  m_en = p_data & 32'hFFFF;
                    15: begin
                        m_int = p_data & 32'hFFFF;
                        if (m_mode == 0) begin h = 1; m_aint = m_int; m_afrac = m_frac; end
                    end
                    16: begin
                        m_frac = p_data & 32'hFFFFFF;
                        if (m_mode == 1) begin h = 1; m_aint = m_int; m_afrac = m_frac; end
                    end
                    18: m_mode = p_data & 1;
                    default: ;
                endcase
            end
            m_hop = h;
            if (wr_req) begin p_vld = 1; p_addr = int'(wr_addr); p_data = int'(wr_data); end
            else if (bit31_stb) p_vld = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, "act_int", int'(act_int), m_aint);
            chk(cur_req, "act_frac", int'(act_frac), m_afrac);
            chk(cur_req, "hop", int'(hop), m_hop);
            chk(cur_req, "frac_mode", int'(frac_mode), m_mode);
            chk(cur_req, "en_out", int'(en_out), m_en);
            chk(cur_req, "pwr_down", int'(pwr_down), (m_en == 0) ? 1 : 0);
            chk(cur_req, "rd_data", int'(rd_data), model_read(int'(rd_addr)));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic req(input int a, input int d);
        wr_req = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        tick(1);
        wr_req = 0;
        tick(3);
    endtask

    task automatic stb();
        bit31_stb = 1;
        tick(1);
        bit31_stb = 0;
        tick(2);
    endtask

    task automatic wr(input int a, input int d);
        req(a, d);
        stb();
    endtask

    // Watchdog
    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(4);
        cur_req = "R1";
        rd_addr = 8'h0F; tick(1);
        chk("R1", "reset int shadow", int'(rd_data), 32'h50);
        chk("R1", "reset act_int", int'(act_int), 0);
        rst_n = 1; tick(2);

        cur_req = "R2";
        rd_addr = 8'h0F;
        req(8'h0F, 24'h001234);
        chk("R2", "shadow before strobe", int'(rd_data), 32'h50);
        stb();
        chk("R2", "shadow after strobe", int'(rd_data), 32'h1234);
        stb();

        cur_req = "R3";
        wr(8'h0F, 24'hFF0123);
        chk("R3", "act_int held", int'(act_int), 0);

        cur_req = "R4";
        rd_addr = 8'h10;
        req(8'h10, 24'hABCDEF);
        bit31_stb = 1; tick(1); bit31_stb = 0;
        chk("R4", "hop pulse", int'(hop), 1);
        chk("R4", "act_frac", int'(act_frac), 32'hABCDEF);
        chk("R4", "act_int", int'(act_int), 32'h0123);
        tick(1);
        chk("R4", "hop one cycle", int'(hop), 0);
        tick(2);

        cur_req = "R10";
        rd_addr = 8'h0F;
        wr(8'h0F, 24'h000777);
        chk("R10", "read returns shadow", int'(rd_data), 32'h777);
        chk("R10", "active unchanged", int'(act_int), 32'h0123);

        cur_req = "R5";
        wr(8'h12, 0);
        wr(8'h0F, 24'h000999);
        chk("R5", "int mode act_int", int'(act_int), 32'h999);
        chk("R5", "int mode act_frac", int'(act_frac), 32'hABCDEF);

        cur_req = "R6";
        rd_addr = 8'h10;
        wr(8'h10, 24'h111111);
        chk("R6", "frac shadow", int'(rd_data), 32'h111111);
        chk("R6", "act_frac held", int'(act_frac), 32'hABCDEF);

        cur_req = "R9";
        rd_addr = 8'h01;
        wr(8'h01, 0);
        chk("R9", "pwr_down", int'(pwr_down), 1);
        wr(8'h01, 24'h00A5A5);
        chk("R9", "restore", int'(rd_data), 32'hA5A5);
        wr(8'h01, 24'h003C0F);

        cur_req = "R11";
        wr(8'h33, 24'h00FFFF);
        rd_addr = 8'h33; tick(1);
        chk("R11", "unmapped read", int'(rd_data), 0);
        rd_addr = 8'h00; tick(1);

        cur_req = "R7";
        wr(8'h00, 1);
        rd_addr = 8'h0F; tick(1);
        chk("R7", "int default", int'(rd_data), 32'h50);
        chk("R7", "active kept", int'(act_int), 32'h999);
        chk("R7", "mode default", int'(frac_mode), 1);

        cur_req = "R8";
        wr(8'h0F, 24'h000ABC);
        wr(8'h10, 24'h222222);
        wr(8'h12, 0);
        wr(8'h00, 2);
        chk("R8", "act cleared", int'(act_int), 0);
        chk("R8", "mode kept", int'(frac_mode), 0);
        chk("R8", "shadow kept", int'(rd_data), 32'hABC);
        wr(8'h00, 3);
        wr(8'h0F, 24'h000321);

        cur_req = "R1";
        rst_n = 0; tick(3);
        chk("R1", "hw reset int", int'(rd_data), 32'h50);
        chk("R1", "hw reset mode", int'(frac_mode), 1);
        rst_n = 1; tick(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule